// File: doc/BRIEF.md
# Strap-Decoded Local-Bus Target

This block is a synchronous 32-bit target on a 486-class local bus and is clocked by the bus clock. While reset is held low it takes in a 4-bit identity strap and a 3-bit bus-mode strap. It keeps both values until the next reset. A cycle starts when the address strobe is sampled low. The block then checks the address against a fixed upper byte built from the identity strap. It sorts the lower 24 address bits into one of five regions with fixed bit patterns. A base and limit compare is not used.

For a cycle that decodes, the block drives device-select low and inserts a fixed number of wait states. It then pulses local-ready for one clock and waits for the host's ready-return. Reads are answered from small internal storage, and writes update that storage lane by lane under the byte enables. A cycle that does not decode gets no response of any kind.

Top module: `lbus_strap_target`

## Requirements
- R1: While `rst_n` is low, `ldev_n` and `lrdy_n` are high, `dat_oe` is low and `strap_id`/`strap_mode` are captured. After reset is released, changes on the strap inputs have no effect on decoding. All storage reads as zero after reset.
- R2: A cycle decodes only when `addr[31:30]`=00, `addr[25:24]`=00 and `addr[29:26]` equals the captured identity strap. For example, strap 0101 gives an upper address byte of 14h. Any other upper byte leaves `ldev_n` and `lrdy_n` high.
- R3: Decoding is enabled only when the captured mode strap is 101 and `mem_io`=1 (memory cycle). Mode 100 and every other mode value give no response to any address.
- R4: After the edge that samples `ads_n` low on a decoding address, `ldev_n` is low from the next cycle until completion. `lrdy_n` is low for exactly one clock, which is the (WAIT_STATES+1)-th cycle after that edge.
- R5: The cycle completes on the first edge, at or after the `lrdy_n` cycle, that samples `rdyrtn_n` low. `ldev_n` is high in the next cycle. An `ads_n` low while a cycle is in progress is ignored, and its address and data are not written.
- R6: Memory region: `addr[23:21]`=000. This covers both 1 MB halves, which alias onto one scratch file of 2**MEM_AW words indexed by `addr[MEM_AW+1:2]`. `addr[1:0]` are don't-care.
- R7: Mapped I/O region: `addr[23:16]`=80h, using a byte file of 2**IO_AW entries indexed by `addr[IO_AW+1:2]`. A write stores the byte on the lowest-numbered lane whose `be_n` bit is 0. A read returns that byte on lane `addr[13:12]` (lane k is bits 8k+7:8k), with all other lanes zero.
- R8: Port region: `addr[23:17]`=1000101, `addr[15:13]`=110 and `addr[1:0]`=00. It selects one of eight 32-bit ports by `addr[12:10]`. `addr[16]` is don't-care.
- R9: Video-buffer window: `addr[23:17]`=1000101, `addr[15:12]`=1110 and `addr[1:0]`=00. It holds 2**TV_AW words indexed by `addr[TV_AW+1:2]`, and higher offsets alias.
- R10: Coprocessor registers: `addr[23:17]`=1000101, `addr[15:12]`=1111 and `addr[1:0]`=00. There are 2**CR_AW words indexed by `addr[CR_AW+1:2]`.
- R11: Inside the 1000101 group, a nonzero `addr[1:0]` decodes nothing. A lower-24 pattern outside R6 to R10 also decodes nothing.
- R12: Writes to memory, ports, video buffer and coprocessor registers update only the lanes whose `be_n` bit is 0. Read data appears on `dat_out` with `dat_oe` high only in the `lrdy_n` cycle of a read. `dat_oe` stays low for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while low |
| strap_id | input | 4 | Identity strap, becomes address bits 29:26 |
| strap_mode | input | 3 | Bus-mode strap, 101 enables decoding |
| ads_n | input | 1 | Address strobe, active low |
| addr | input | 32 | Byte address |
| be_n | input | 4 | Byte enables, active low |
| wr_rd | input | 1 | 1 for write, 0 for read |
| mem_io | input | 1 | 1 for memory cycle, 0 for I/O |
| dat_in | input | 32 | Write data from host |
| dat_out | output | 32 | Read data to host |
| dat_oe | output | 1 | Read data drive enable |
| ldev_n | output | 1 | Device select, active low |
| lrdy_n | output | 1 | Local ready, active low |
| rdyrtn_n | input | 1 | Ready return from host, active low |

## Verification
The bench builds the block with WAIT_STATES=2, so the wait counter has to count through more than one state before ready appears. It uses MEM_AW=3, IO_AW=2, TV_AW=4 and CR_AW=2, which keeps every storage file small. With files this small, aliasing across the two memory halves and across the video window falls within short address offsets. A behavioural reference model predicts `ldev_n` and `lrdy_n` on every clock of each transfer, along with the read data. It is also run against delayed ready-return, strobes issued during a busy cycle, and a reset into the non-linear mode.

// File: rtl/lbus_strap_target.sv
`timescale 1ns/1ps
module lbus_strap_target #(
  parameter int WAIT_STATES = 1,
  parameter int MEM_AW = 3,
  parameter int IO_AW = 3,
  parameter int TV_AW = 4,
  parameter int CR_AW = 3
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  strap_id,
  input  logic [2:0]  strap_mode,
  input  logic        ads_n,
  input  logic [31:0] addr,
  input  logic [3:0]  be_n,
  input  logic        wr_rd,
  input  logic        mem_io,
  input  logic [31:0] dat_in,
  output logic [31:0] dat_out,
  output logic        dat_oe,
  output logic        ldev_n,
  output logic        lrdy_n,
  input  logic        rdyrtn_n
);
  localparam int CW = (WAIT_STATES < 2) ? 1 : $clog2(WAIT_STATES);
  localparam int M1 = (MEM_AW > IO_AW) ? MEM_AW : IO_AW;
  localparam int M2 = (TV_AW > CR_AW) ? TV_AW : CR_AW;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int IXW = (M3 > 3) ? M3 : 3;
  localparam logic [2:0] LINEAR = 3'b101;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RDY, ST_DONE} st_t;
  typedef enum logic [2:0] {RG_NONE, RG_MEM, RG_IO, RG_PORT, RG_TV, RG_CR} rg_t;

  st_t st;
  rg_t rg_d, rg_q;
  logic [CW-1:0]  cnt;
  logic [3:0]     strap_q;
  logic [2:0]     mode_q;
  logic [IXW-1:0] ix_d, ix_q;
  logic [1:0]     lane_q;
  logic [3:0]     be_q;
  logic           wr_q;

  logic [31:0] mem_q  [2**MEM_AW];
  logic [7:0]  io_q   [2**IO_AW];
  logic [31:0] port_q [8];
  logic [31:0] tv_q   [2**TV_AW];
  logic [31:0] cr_q   [2**CR_AW];

  always_ff @(posedge clk)
    if (!rst_n) begin
      strap_q <= strap_id;
      mode_q  <= strap_mode;
    end

  logic upper_hit, grp_hit;
  assign upper_hit = (mode_q == LINEAR) && mem_io && addr[31:30] == 2'b00 &&
                     addr[25:24] == 2'b00 && addr[29:26] == strap_q;
  assign grp_hit = addr[23:17] == 7'b1000101 && addr[1:0] == 2'b00;

  always_comb begin
    rg_d = RG_NONE;
    ix_d = '0;
    if (upper_hit) begin
      if (addr[23:21] == 3'b000) begin
        rg_d = RG_MEM;  ix_d = IXW'(addr[MEM_AW+1:2]);
      end else if (addr[23:16] == 8'h80) begin
        rg_d = RG_IO;   ix_d = IXW'(addr[IO_AW+1:2]);
      end else if (grp_hit && addr[15:13] == 3'b110) begin
        rg_d = RG_PORT; ix_d = IXW'(addr[12:10]);
      end else if (grp_hit && addr[15:12] == 4'b1110) begin
        rg_d = RG_TV;   ix_d = IXW'(addr[TV_AW+1:2]);
      end else if (grp_hit && addr[15:12] == 4'b1111) begin
        rg_d = RG_CR;   ix_d = IXW'(addr[CR_AW+1:2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; rg_q <= RG_NONE; ix_q <= '0;
      lane_q <= '0; be_q <= '1; wr_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (!ads_n && rg_d != RG_NONE) begin
          rg_q <= rg_d; ix_q <= ix_d; lane_q <= addr[13:12];
          be_q <= be_n; wr_q <= wr_rd;
          if (WAIT_STATES == 0) st <= ST_RDY;
          else begin st <= ST_WAIT; cnt <= CW'(WAIT_STATES - 1); end
        end
        ST_WAIT: if (cnt == '0) st <= ST_RDY; else cnt <= cnt - 1'b1;
        ST_RDY:  st <= rdyrtn_n ? ST_DONE : ST_IDLE;
        default: if (!rdyrtn_n) st <= ST_IDLE;
      endcase
    end

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] ben);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = ben[i] ? old[8*i +: 8] : nw[8*i +: 8];
    return r;
  endfunction

  logic [7:0] io_byte;
  logic       io_any;
  always_comb begin
    io_byte = '0;
    io_any  = 1'b0;
    for (int i = 3; i >= 0; i--)
      if (!be_q[i]) begin io_byte = dat_in[8*i +: 8]; io_any = 1'b1; end
  end

  logic commit;
  assign commit = (st == ST_RDY) && wr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 2**MEM_AW; i++) mem_q[i] <= '0;
      for (int i = 0; i < 2**IO_AW; i++)  io_q[i]  <= '0;
      for (int i = 0; i < 8; i++)         port_q[i] <= '0;
      for (int i = 0; i < 2**TV_AW; i++)  tv_q[i]  <= '0;
      for (int i = 0; i < 2**CR_AW; i++)  cr_q[i]  <= '0;
    end else if (commit) begin
      case (rg_q)
        RG_MEM:  mem_q[ix_q[MEM_AW-1:0]] <= merge(mem_q[ix_q[MEM_AW-1:0]], dat_in, be_q);
        RG_IO:   if (io_any) io_q[ix_q[IO_AW-1:0]] <= io_byte;
        RG_PORT: port_q[ix_q[2:0]] <= merge(port_q[ix_q[2:0]], dat_in, be_q);
        RG_TV:   tv_q[ix_q[TV_AW-1:0]] <= merge(tv_q[ix_q[TV_AW-1:0]], dat_in, be_q);
        RG_CR:   cr_q[ix_q[CR_AW-1:0]] <= merge(cr_q[ix_q[CR_AW-1:0]], dat_in, be_q);
        default: ;
      endcase
    end

  logic [31:0] rd_word;
  always_comb
    case (rg_q)
      RG_MEM:  rd_word = mem_q[ix_q[MEM_AW-1:0]];
      RG_IO:   rd_word = 32'(io_q[ix_q[IO_AW-1:0]]) << {lane_q, 3'b000};
      RG_PORT: rd_word = port_q[ix_q[2:0]];
      RG_TV:   rd_word = tv_q[ix_q[TV_AW-1:0]];
      RG_CR:   rd_word = cr_q[ix_q[CR_AW-1:0]];
      default: rd_word = '0;
    endcase

  assign dat_oe  = rst_n && (st == ST_RDY) && !wr_q;
  assign dat_out = dat_oe ? rd_word : '0;
  assign ldev_n  = !(rst_n && st != ST_IDLE);
  assign lrdy_n  = !(rst_n && st == ST_RDY);
endmodule

// File: rtl/lbus_strap_target_chk.sv
`timescale 1ns/1ps
module lbus_strap_target_chk (
  input logic clk,
  input logic rst_n,
  input logic ads_n,
  input logic ldev_n,
  input logic lrdy_n,
  input logic rdyrtn_n,
  input logic dat_oe
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (ldev_n && lrdy_n && !dat_oe));  // R1

  AST_LRDY_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !lrdy_n |=> lrdy_n);  // R4

  AST_LRDY_UNDER_LDEV: assert property (@(posedge clk) disable iff (!rst_n)
    !lrdy_n |-> !ldev_n);  // R4

  AST_LDEV_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ldev_n) |-> $past(!ads_n));  // R4

  AST_RELEASE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (!lrdy_n && !rdyrtn_n) |=> ldev_n);  // R5

  AST_OE_IN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> !lrdy_n);  // R12
endmodule

bind lbus_strap_target lbus_strap_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .ldev_n(ldev_n),
  .lrdy_n(lrdy_n), .rdyrtn_n(rdyrtn_n), .dat_oe(dat_oe)
);

// File: tb/tb_lbus_strap_target.sv
`timescale 1ns/1ps
module tb_lbus_strap_target;
  localparam int WS = 2, MAW = 3, IAW = 2, TAW = 4, CAW = 2;

  logic clk = 0, rst_n = 0;
  logic [3:0] strap_id = 4'b0101;
  logic [2:0] strap_mode = 3'b101;
  logic ads_n = 1, wr_rd = 0, mem_io = 1, rdyrtn_n = 1;
  logic [31:0] addr = '0, dat_in = '0;
  logic [3:0] be_n = '1;
  logic [31:0] dat_out;
  logic dat_oe, ldev_n, lrdy_n;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_linear = 1;
  logic [3:0] m_id = 4'b0101;

  logic [31:0] m_mem [2**MAW];
  logic [7:0]  m_io  [2**IAW];
  logic [31:0] m_port[8];
  logic [31:0] m_tv  [2**TAW];
  logic [31:0] m_cr  [2**CAW];

  lbus_strap_target #(.WAIT_STATES(WS), .MEM_AW(MAW), .IO_AW(IAW), .TV_AW(TAW), .CR_AW(CAW)) dut (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .strap_mode(strap_mode),
    .ads_n(ads_n), .addr(addr), .be_n(be_n), .wr_rd(wr_rd), .mem_io(mem_io),
    .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe), .ldev_n(ldev_n),
    .lrdy_n(lrdy_n), .rdyrtn_n(rdyrtn_n));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int region(input logic [31:0] a, input logic mio);
    if (!m_linear || !mio || a[31:24] != {2'b00, m_id, 2'b00}) return 0;
    casez (a[23:0])
      24'b000?_????_????_????_????_????: return 1;
      24'b1000_0000_????_????_????_????: return 2;
      24'b1000_101?_110?_????_????_??00: return 3;
      24'b1000_101?_1110_????_????_??00: return 4;
      24'b1000_101?_1111_????_????_??00: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n, input logic [3:0] b);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (!b[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [31:0] a, input int rg);
    case (rg)
      1: return m_mem[a[MAW+1:2]];
      2: return {24'h0, m_io[a[IAW+1:2]]} << (8 * a[13:12]);
      3: return m_port[a[12:10]];
      4: return m_tv[a[TAW+1:2]];
      5: return m_cr[a[CAW+1:2]];
      default: return '0;
    endcase
  endfunction

  task automatic m_write(input logic [31:0] a, input int rg, input logic [3:0] b, input logic [31:0] d);
    case (rg)
      1: m_mem[a[MAW+1:2]] = lanes(m_mem[a[MAW+1:2]], d, b);
      2: begin
           int ln = -1;
           for (int i = 3; i >= 0; i--) if (!b[i]) ln = i;
           if (ln >= 0) m_io[a[IAW+1:2]] = d[8*ln +: 8];
         end
      3: m_port[a[12:10]] = lanes(m_port[a[12:10]], d, b);
      4: m_tv[a[TAW+1:2]] = lanes(m_tv[a[TAW+1:2]], d, b);
      5: m_cr[a[CAW+1:2]] = lanes(m_cr[a[CAW+1:2]], d, b);
      default: ;
    endcase
  endtask

  task automatic m_clear();
    for (int i = 0; i < 2**MAW; i++) m_mem[i] = '0;
    for (int i = 0; i < 2**IAW; i++) m_io[i] = '0;
    for (int i = 0; i < 8; i++) m_port[i] = '0;
    for (int i = 0; i < 2**TAW; i++) m_tv[i] = '0;
    for (int i = 0; i < 2**CAW; i++) m_cr[i] = '0;
  endtask

  task automatic bus(input logic [31:0] a, input logic [3:0] b, input bit wr,
                     input logic [31:0] d, input logic mio, input int rr_dly,
                     input bit hold, input string req);
    int rg = region(a, mio);
    logic [31:0] expd = m_read(a, rg);
    @(negedge clk);
    ads_n = 0; addr = a; be_n = b; wr_rd = wr; dat_in = d; mem_io = mio;
    @(negedge clk);
    if (hold) begin
      addr = a ^ 32'h0000_0004; dat_in = ~d; be_n = 4'b0000; wr_rd = 1;
    end else ads_n = 1;
    if (rg == 0) begin
      for (int k = 0; k < WS + 2; k++) begin
        chk(ldev_n && lrdy_n, {req, " no response"}, {30'h0, ldev_n, lrdy_n}, 32'h3);
        @(negedge clk);
      end
      ads_n = 1;
      return;
    end
    for (int k = 0; k < WS; k++) begin
      chk(!ldev_n && lrdy_n, {req, " R4 wait state"}, {30'h0, ldev_n, lrdy_n}, 32'h1);
      @(negedge clk);
    end
    ads_n = 1; addr = a; dat_in = d; be_n = b; wr_rd = wr;
    chk(!ldev_n && !lrdy_n, {req, " R4 ready cycle"}, {30'h0, ldev_n, lrdy_n}, 32'h0);
    if (wr) chk(!dat_oe, {req, " R12 no drive on write"}, {31'h0, dat_oe}, 32'h0);
    else begin
      chk(dat_oe, {req, " R12 drive on read"}, {31'h0, dat_oe}, 32'h1);
      chk(dat_out == expd, {req, " read data"}, dat_out, expd);
    end
    if (wr) m_write(a, rg, b, d);
    for (int k = 0; k < rr_dly; k++) begin
      @(negedge clk);
      chk(!ldev_n && lrdy_n, {req, " R5 awaiting return"}, {30'h0, ldev_n, lrdy_n}, 32'h1);
      chk(!dat_oe, {req, " R12 drive only in ready"}, {31'h0, dat_oe}, 32'h0);
    end
    rdyrtn_n = 0;
    @(negedge clk);
    rdyrtn_n = 1;
    chk(ldev_n && lrdy_n, {req, " R5 released"}, {30'h0, ldev_n, lrdy_n}, 32'h3);
  endtask

  task automatic do_reset(input logic [3:0] id, input logic [2:0] md);
    @(negedge clk);
    rst_n = 0; strap_id = id; strap_mode = md;
    repeat (3) @(negedge clk);
    chk(ldev_n && lrdy_n && !dat_oe, "R1 quiet in reset", {29'h0, ldev_n, lrdy_n, dat_oe}, 32'h6);
    m_id = id; m_linear = (md == 3'b101); m_clear();
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_clear();
    do_reset(4'b0101, 3'b100);
    bus(32'h1400_0008, 4'h0, 1, 32'h1111_2222, 1, 0, 0, "R3 standard mode");
    do_reset(4'b0101, 3'b101);
    strap_id = 4'b1010; strap_mode = 3'b000;
    bus(32'h1400_0008, 4'h0, 0, 0, 1, 0, 0, "R1 reset storage zero");
    bus(32'h1400_0008, 4'h0, 1, 32'hDEAD_BEEF, 1, 0, 0, "R1 R6 mem write after strap change");
    bus(32'h1400_0008, 4'h0, 0, 0, 1, 0, 0, "R6 mem read");
    bus(32'h1410_0028, 4'h0, 0, 0, 1, 0, 0, "R6 second MB alias");
    bus(32'h1400_0004, 4'b1100, 1, 32'hA5A5_1234, 1, 0, 0, "R12 mem lane write");
    bus(32'h1400_0007, 4'h0, 0, 0, 1, 0, 0, "R6 low bits ignored");
    bus(32'h1500_0008, 4'h0, 0, 0, 1, 0, 0, "R2 wrong strap byte");
    bus(32'h5400_0008, 4'h0, 0, 0, 1, 0, 0, "R2 bit30 set");
    bus(32'h1500_0008 ^ 32'h0100_0000 | 32'h0100_0000, 4'h0, 0, 0, 1, 0, 0, "R2 bit24 set");
    bus(32'h1400_0008, 4'h0, 0, 0, 0, 0, 0, "R3 io cycle");
    bus(32'h1480_0010, 4'b1001, 1, 32'hAABB_CCDD, 1, 0, 0, "R7 io write");
    bus(32'h1480_2010, 4'h0, 0, 0, 1, 0, 0, "R7 io read lane2");
    bus(32'h1480_0010, 4'h0, 0, 0, 1, 0, 0, "R7 io read lane0");
    bus(32'h1480_0014, 4'b0111, 1, 32'h9900_0000, 1, 0, 0, "R7 io write lane3");
    bus(32'h1480_3014, 4'h0, 0, 0, 1, 0, 0, "R7 io read lane3");
    bus(32'h148A_D400, 4'h0, 1, 32'h0123_4567, 1, 0, 0, "R8 port5 write");
    bus(32'h148B_D400, 4'h0, 0, 0, 1, 0, 0, "R8 port5 via bit16");
    bus(32'h148A_C800, 4'b0111, 1, 32'h7700_0000, 1, 0, 0, "R8 R12 port2 lane3");
    bus(32'h148A_C800, 4'h0, 0, 0, 1, 0, 0, "R8 port2 read");
    bus(32'h148A_E004, 4'h0, 1, 32'hCAFE_F00D, 1, 0, 0, "R9 tv write");
    bus(32'h148A_E044, 4'h0, 0, 0, 1, 0, 0, "R9 tv alias");
    bus(32'h148A_F008, 4'h0, 1, 32'h5555_AAAA, 1, 0, 0, "R10 cop write");
    bus(32'h148A_F018, 4'h0, 0, 0, 1, 0, 0, "R10 cop alias read");
    bus(32'h148A_F00A, 4'h0, 1, 32'hFFFF_FFFF, 1, 0, 0, "R11 low bits in group");
    bus(32'h1460_0000, 4'h0, 0, 0, 1, 0, 0, "R11 unmapped pattern");
    bus(32'h148A_F008, 4'h0, 0, 0, 1, 0, 0, "R11 cop unchanged");
    bus(32'h148A_F008, 4'h0, 0, 0, 1, 3, 0, "R5 delayed return");
    bus(32'h148A_F000, 4'h0, 1, 32'h1357_9BDF, 1, 1, 1, "R5 strobe while busy");
    bus(32'h148A_F004, 4'h0, 0, 0, 1, 0, 0, "R5 busy strobe not written");
    bus(32'h148A_F000, 4'h0, 0, 0, 1, 0, 0, "R10 cop word0");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule